// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Flag

This block is a combinational 32-bit shifter. It takes its shift count from the bottom byte of a register word. It performs one of four operations: logical left, logical right, arithmetic right or rotate right. Alongside the shifted value it produces a new carry flag, following the carry rules that a processor datapath uses when the amount is not a constant.

A two-bit kind code selects the operation. The caller supplies the current carry flag. When the effective amount is zero, that flag passes through unchanged. Amounts of exactly the word width and amounts beyond it each have their own result and carry behaviour. A datapath places the block between operand fetch and the ALU, and registers the outputs where its pipeline needs them.

Top module: `reg_shift_carry`

## Requirements
- R1: Only bits 7:0 of `amount_i` form the shift count; bits 31:8 have no effect on `result_o` or `carry_o`.
- R2: A count of zero gives `result_o` equal to `operand_i` and `carry_o` equal to `carry_i`, for every kind.
- R3: Kind 2'b00 is a logical left shift. For counts 1 to 31 the result is the operand shifted left with zero fill, and the carry is operand bit (32 - count).
- R4: For a logical left shift by exactly 32, the result is zero and the carry is operand bit 0. For counts of 33 to 255, the result and the carry are both zero.
- R5: Kind 2'b01 is a logical right shift. Counts 1 to 31 give zero fill, with the carry taken from operand bit (count - 1). A count of 32 gives zero with the carry equal to bit 31. Counts of 33 and above give zero with a clear carry.
- R6: Kind 2'b10 is an arithmetic right shift. For counts 1 to 31 it fills with bit 31 and the carry is bit (count - 1). For counts of 32 and above, every result bit and the carry equal operand bit 31.
- R7: Kind 2'b11 is a rotate right by (count mod 32). When that value is zero but the count is non-zero, the result equals the operand and the carry is bit 31.
- R8: For a rotate whose (count mod 32) is non-zero, the carry is operand bit ((count mod 32) - 1). The result holds the same number of set bits as the operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to shift |
| amount_i | input | 32 | Register word whose low byte is the shift count |
| kind_i | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_i | input | 1 | Carry flag before the operation |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Carry flag after the operation |

## Verification
The bound checker re-evaluates its rules every time an input changes. These rules cover the zero-count passthrough, the boundary results at exactly 32 and beyond for each kind, the rotate-by-multiple-of-32 case and the preservation of set bits under rotation.

Only the directed scenarios can show the following:
- The carry is taken from the correct interior bit for counts 1 to 31.
- The upper amount bits are really ignored, which needs a comparison between two stimuli.
- Fill bits are correct for ordinary shifts.

The bench checks these against a model that shifts one position per step.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    KIND_LSL = 2'b00,
    KIND_LSR = 2'b01,
    KIND_ASR = 2'b10,
    KIND_ROR = 2'b11
  } shift_kind_e;

  // Rotate right by r (r < W), as a pair of logical shifts.
  function automatic logic [31:0] rot_right32(input logic [31:0] v, input logic [4:0] r);
    logic [5:0] back;
    back = 6'd32 - {1'b0, r};
    if (r == 5'd0) return v;
    return (v >> r) | (v << back);
  endfunction

endpackage

// File: rtl/rsc_amount_decode.sv
module rsc_amount_decode #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] amount_word,
  output logic [AMT_W-1:0]  count,
  output logic [LOG_W-1:0]  count_low,
  output logic              is_zero,
  output logic              is_full,
  output logic              is_over,
  output logic              rot_zero
);
  logic unused_high_bits;

  assign count            = amount_word[AMT_W-1:0];
  assign unused_high_bits = ^amount_word[DATA_W-1:AMT_W];
  assign count_low        = count[LOG_W-1:0];
  assign is_zero          = (count == '0);
  assign is_full          = (count == AMT_W'(DATA_W));
  assign is_over          = (count >  AMT_W'(DATA_W));
  assign rot_zero         = (count_low == '0);
endmodule

// File: rtl/rsc_value_path.sv
module rsc_value_path
  import rsc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  shift_kind_e       kind,
  input  logic [LOG_W-1:0]  count_low,
  input  logic              is_zero,
  input  logic              wide,      // count >= DATA_W
  output logic [DATA_W-1:0] value
);
  always_comb begin
    value = operand;
    if (!is_zero) begin
      unique case (kind)
        KIND_LSL: value = wide ? '0 : (operand << count_low);
        KIND_LSR: value = wide ? '0 : (operand >> count_low);
        KIND_ASR: value = wide ? {DATA_W{operand[DATA_W-1]}}
                               : DATA_W'($signed(operand) >>> count_low);
        KIND_ROR: value = rot_right32(operand, count_low);
        default:  value = operand;
      endcase
    end
  end
endmodule

// File: rtl/rsc_carry_path.sv
module rsc_carry_path
  import rsc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  shift_kind_e       kind,
  input  logic [LOG_W-1:0]  count_low,
  input  logic              carry_in,
  input  logic              is_zero,
  input  logic              is_full,
  input  logic              is_over,
  input  logic              rot_zero,
  output logic              carry
);
  logic [LOG_W-1:0] left_idx;
  logic [LOG_W-1:0] right_idx;
  logic             msb;

  // DATA_W - n wraps to the correct index in LOG_W bits for n in 1..DATA_W-1.
  assign left_idx  = LOG_W'(0) - count_low;
  assign right_idx = count_low - LOG_W'(1);
  assign msb       = operand[DATA_W-1];

  always_comb begin
    carry = carry_in;
    if (!is_zero) begin
      unique case (kind)
        KIND_LSL: carry = is_over ? 1'b0 : (is_full ? operand[0] : operand[left_idx]);
        KIND_LSR: carry = is_over ? 1'b0 : (is_full ? msb : operand[right_idx]);
        KIND_ASR: carry = (is_over || is_full) ? msb : operand[right_idx];
        KIND_ROR: carry = rot_zero ? msb : operand[right_idx];
        default:  carry = carry_in;
      endcase
    end
  end
endmodule

// File: rtl/reg_shift_carry.sv
module reg_shift_carry
  import rsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] amount_i,
  input  logic [1:0]        kind_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  shift_kind_e      kind;
  logic [AMT_W-1:0] count;
  logic [LOG_W-1:0] count_low;
  logic             amt_zero, amt_full, amt_over, rot_zero;

  assign kind = shift_kind_e'(kind_i);

  rsc_amount_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .amount_word(amount_i), .count(count), .count_low(count_low),
    .is_zero(amt_zero), .is_full(amt_full), .is_over(amt_over), .rot_zero(rot_zero)
  );

  rsc_value_path #(.DATA_W(DATA_W)) u_val (
    .operand(operand_i), .kind(kind), .count_low(count_low),
    .is_zero(amt_zero), .wide(amt_full | amt_over), .value(result_o)
  );

  rsc_carry_path #(.DATA_W(DATA_W)) u_cry (
    .operand(operand_i), .kind(kind), .count_low(count_low), .carry_in(carry_i),
    .is_zero(amt_zero), .is_full(amt_full), .is_over(amt_over), .rot_zero(rot_zero),
    .carry(carry_o)
  );
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0] operand_i,
  input logic [1:0]        kind_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              amt_zero,
  input logic              amt_full,
  input logic              amt_over,
  input logic              rot_zero
);
  logic top_bit;
  assign top_bit = operand_i[DATA_W-1];

  always_comb begin
    if (amt_zero)
      assert_zero_passthru_R2: assert (result_o == operand_i && carry_o == carry_i)
        else $error("zero count altered value or carry");
    if (kind_i == 2'b00 && amt_full)
      assert_lsl_full_R4: assert (result_o == '0 && carry_o == operand_i[0])
        else $error("left shift by width wrong");
    if (kind_i == 2'b00 && amt_over)
      assert_lsl_over_R4: assert (result_o == '0 && !carry_o)
        else $error("left shift beyond width wrong");
    if (kind_i == 2'b01 && amt_full)
      assert_lsr_full_R5: assert (result_o == '0 && carry_o == top_bit)
        else $error("right shift by width wrong");
    if (kind_i == 2'b01 && amt_over)
      assert_lsr_over_R5: assert (result_o == '0 && !carry_o)
        else $error("right shift beyond width wrong");
    if (kind_i == 2'b10 && (amt_full || amt_over))
      assert_asr_wide_R6: assert (result_o == {DATA_W{top_bit}} && carry_o == top_bit)
        else $error("wide arithmetic shift wrong");
    if (kind_i == 2'b11 && rot_zero && !amt_zero)
      assert_ror_whole_R7: assert (result_o == operand_i && carry_o == top_bit)
        else $error("rotate by multiple of width wrong");
    if (kind_i == 2'b11)
      assert_ror_popcount_R8: assert ($countones(result_o) == $countones(operand_i))
        else $error("rotate lost or gained bits");
  end
endmodule

bind reg_shift_carry rsc_checker #(.DATA_W(DATA_W)) u_rsc_chk (
  .operand_i(operand_i), .kind_i(kind_i), .carry_i(carry_i),
  .result_o(result_o), .carry_o(carry_o),
  .amt_zero(amt_zero), .amt_full(amt_full), .amt_over(amt_over), .rot_zero(rot_zero)
);

// File: tb/reg_shift_carry_test.sv
module reg_shift_carry_test;
  logic        clk = 1'b0;
  logic [31:0] operand_i = '0;
  logic [31:0] amount_i  = '0;
  logic [1:0]  kind_i    = 2'b00;
  logic        carry_i   = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  reg_shift_carry uut (
    .operand_i(operand_i), .amount_i(amount_i), .kind_i(kind_i),
    .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
  );

  // One-position-per-step model: the carry is whatever bit leaves last.
  function automatic void model(input logic [31:0] op, input logic [7:0] n,
                                input logic [1:0] k, input logic c,
                                output logic [31:0] r, output logic rc);
    r = op; rc = c;
    for (int i = 0; i < int'(n); i++) begin
      case (k)
        2'b00: begin rc = r[31]; r = {r[30:0], 1'b0}; end
        2'b01: begin rc = r[0];  r = {1'b0, r[31:1]}; end
        2'b10: begin rc = r[0];  r = {r[31], r[31:1]}; end
        default: begin rc = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] exp_r, input logic exp_c);
    checks++;
    if (result_o !== exp_r || carry_o !== exp_c) begin
      failures++;
      $display("FAIL %s op=%h amt=%h kind=%0d cin=%0b: got r=%h c=%0b expected r=%h c=%0b",
               tag, operand_i, amount_i, kind_i, carry_i, result_o, carry_o, exp_r, exp_c);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] op, input logic [31:0] amt,
                     input logic [1:0] k, input logic c);
    logic [31:0] er;
    logic        ec;
    @(posedge clk);
    operand_i = op; amount_i = amt; kind_i = k; carry_i = c;
    @(negedge clk);
    model(op, amt[7:0], k, c, er, ec);
    check(tag, er, ec);
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    check("R2 idle inputs", 32'h0, 1'b0);
  endtask

  task automatic test_zero_count();
    for (int k = 0; k < 4; k++) begin
      run("R2 zero count cin=1", 32'hDEAD_BEEF, 32'h0000_0000, 2'(k), 1'b1);
      run("R2 zero count cin=0", 32'h8000_0001, 32'h1234_5600, 2'(k), 1'b0);
    end
  endtask

  task automatic test_left();
    run("R3 lsl 1",   32'h8000_0001, 32'd1,  2'b00, 1'b0);
    run("R3 lsl 4",   32'h1234_5678, 32'd4,  2'b00, 1'b0);
    run("R3 lsl 31",  32'h0000_0003, 32'd31, 2'b00, 1'b0);
    run("R4 lsl 32",  32'h0000_0001, 32'd32, 2'b00, 1'b0);
    run("R4 lsl 32b", 32'hFFFF_FFFE, 32'd32, 2'b00, 1'b1);
    run("R4 lsl 33",  32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1);
    run("R4 lsl 255", 32'hFFFF_FFFF, 32'd255, 2'b00, 1'b1);
  endtask

  task automatic test_logical_right();
    run("R5 lsr 1",   32'h0000_0001, 32'd1,  2'b01, 1'b0);
    run("R5 lsr 17",  32'hA5A5_5A5A, 32'd17, 2'b01, 1'b0);
    run("R5 lsr 31",  32'hC000_0000, 32'd31, 2'b01, 1'b0);
    run("R5 lsr 32",  32'h8000_0000, 32'd32, 2'b01, 1'b0);
    run("R5 lsr 40",  32'hFFFF_FFFF, 32'd40, 2'b01, 1'b1);
  endtask

  task automatic test_arith_right();
    run("R6 asr 1 neg",  32'h8000_0003, 32'd1,  2'b10, 1'b0);
    run("R6 asr 12",     32'h9ABC_DEF0, 32'd12, 2'b10, 1'b1);
    run("R6 asr 32 neg", 32'h8000_0000, 32'd32, 2'b10, 1'b0);
    run("R6 asr 200",    32'h7FFF_FFFF, 32'd200, 2'b10, 1'b1);
    run("R6 asr 77 neg", 32'hF000_0000, 32'd77, 2'b10, 1'b0);
  endtask

  task automatic test_rotate();
    run("R7 ror 32",  32'h8000_1234, 32'd32, 2'b11, 1'b0);
    run("R7 ror 64",  32'h0000_1234, 32'd64, 2'b11, 1'b1);
    run("R7 ror 224", 32'h8765_4321, 32'd224, 2'b11, 1'b0);
    run("R8 ror 1",   32'h0000_0001, 32'd1,  2'b11, 1'b0);
    run("R8 ror 8",   32'h1234_5678, 32'd8,  2'b11, 1'b0);
    run("R8 ror 33",  32'h0000_0002, 32'd33, 2'b11, 1'b0);
    run("R8 ror 255", 32'h8000_0000, 32'd255, 2'b11, 1'b0);
  endtask

  task automatic test_upper_ignored();
    // Same low byte, junk above: model uses only bits 7:0.
    run("R1 hi bits lsl", 32'h0F0F_0F0F, 32'hFFFF_FF04, 2'b00, 1'b0);
    run("R1 hi bits lsr", 32'h0F0F_0F0F, 32'h0000_0100, 2'b01, 1'b1);
    run("R1 hi bits asr", 32'h8F0F_0F0F, 32'h8000_0020, 2'b10, 1'b0);
    run("R1 hi bits ror", 32'h0F0F_0F0F, 32'h1234_5600, 2'b11, 1'b1);
  endtask

  task automatic test_sweep();
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 70; n++)
        run("R3 R5 R6 R8 sweep", 32'hB3C5_2E91 ^ (32'(n) << 7), 32'(n), 2'(k), n[0]);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset_state();
    test_zero_count();
    test_left();
    test_logical_right();
    test_arith_right();
    test_rotate();
    test_upper_ignored();
    test_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule